// File: doc/BRIEF.md
# Accumulator Arithmetic Unit with Condition Code Register

This block holds an 8-bit accumulator and an 8-bit condition code register. Each clock cycle it can perform one operation on the accumulator and an operand byte: load, binary add, add with carry, subtract, subtract with borrow, or a decimal adjust that turns the sum of two packed-BCD bytes into a valid packed-BCD result. The arithmetic operations update the carry, overflow, zero, negative and half-carry flags. Only the add family updates the half-carry flag. The decimal adjust reads the half-carry and carry flags.

The same register holds three control bits: a stop-disable bit, a mask for the non-maskable interrupt line and a mask for the maskable interrupt lines. Reset sets all three. A register write port can change them, except that the non-maskable mask can only be cleared by a write. The block gates a stop request and the interrupt request lines with these bits and drives registered outputs. A surrounding processor supplies the operation code and the operand. Instruction fetch and decoding are outside this block.

Top module: `acc_flag_unit`

## Requirements
- R1: Reset (synchronous, active high) sets the accumulator to 0x00, sets CCR bits 7 (stop-disable), 6 (NMI mask) and 4 (IRQ mask) to 1, drives all gated outputs low, and leaves CCR bits 5, 3, 2, 1 and 0 at the values they had before reset.
- R2: Operation code 1 (load) copies the operand into the accumulator and leaves the CCR unchanged. Codes 0 and 7 change nothing.
- R3: Codes 2 (add) and 3 (add with carry in CCR bit 0) put the sum in the accumulator. CCR bit 0 (C) takes the carry out of bit 7. CCR bit 1 (V) is set when both inputs have the same sign and the result sign differs. CCR bit 5 (H) takes the carry out of bit 3.
- R4: Codes 4 (subtract) and 5 (subtract with borrow in C) put accumulator minus operand in the accumulator. C is set on a borrow. V is set when the operand signs differ and the result sign differs from the accumulator sign. H is left unchanged.
- R5: After any of codes 2 to 6, CCR bit 3 (N) equals bit 7 of the new accumulator and CCR bit 2 (Z) is set exactly when the new accumulator is zero.
- R6: Code 6 (decimal adjust) adds 0x06 when H is 1 or the low nibble is above 9. It adds 0x60 and sets C when C is 1, when the high nibble is above 9, or when the high nibble is 9 and the low nibble is above 9. Otherwise C is cleared. H and V are left unchanged.
- R7: A CCR write (write strobe high) loads every bit from the write data except bit 6, which becomes the old bit 6 AND the written bit, so that only reset can set it again.
- R8: A CCR write in the same cycle as an operation takes priority over the operation's flag update. The accumulator is still updated.
- R9: One cycle after the inputs are sampled, the stop-enable output equals the stop request AND NOT bit 7, the NMI output equals the NMI request AND NOT bit 6, and the IRQ output equals the OR of the IRQ lines AND NOT bit 4, all using the CCR value held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation code |
| opnd_i | input | 8 | Operand byte |
| ccr_we_i | input | 1 | CCR write strobe |
| ccr_wdata_i | input | 8 | CCR write data |
| stop_req_i | input | 1 | Raw stop request |
| nmi_req_i | input | 1 | Raw non-maskable interrupt request |
| irq_req_i | input | N_IRQ | Raw maskable interrupt requests |
| acc_o | output | 8 | Accumulator value |
| ccr_o | output | 8 | Condition code register value |
| stop_en_o | output | 1 | Gated stop request |
| nmi_o | output | 1 | Gated non-maskable interrupt |
| irq_o | output | 1 | Gated maskable interrupt |

## Verification
The decimal-adjust cases cover a low-nibble fix from H, a low-nibble fix from a digit above 9 that carries into a high nibble of 9 (0x9A becomes 0x00 with C set), and a high-nibble fix alone. A design that ignores any one of these conditions leaves a non-BCD byte or a wrong carry. Subtraction is run with H set beforehand, so a design that recomputes H on subtract clears it. A write that tries to set the NMI mask again, and a write issued together with an add, show whether the sticky rule and the write priority are kept. Reset is applied with known flags to show that the arithmetic flags survive it. The gated outputs are sampled in the cycle of the mask write and in the cycle after it, which exposes a design that gates on the new mask one cycle early.

// File: rtl/acc_flag_pkg.sv
package acc_flag_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_LOAD = 3'd1,
    OP_ADD  = 3'd2,
    OP_ADC  = 3'd3,
    OP_SUB  = 3'd4,
    OP_SBC  = 3'd5,
    OP_DAA  = 3'd6,
    OP_NOP7 = 3'd7
  } acc_op_e;

  // bit positions inside the condition code register
  localparam int B_STOP = 7;
  localparam int B_NMIM = 6;
  localparam int B_HALF = 5;
  localparam int B_IRQM = 4;
  localparam int B_NEG  = 3;
  localparam int B_ZERO = 2;
  localparam int B_OVF  = 1;
  localparam int B_CRY  = 0;
endpackage

// File: rtl/acc_arith.sv
module acc_arith
  import acc_flag_pkg::*;
(
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cry_o,
  output logic              ovf_o,
  output logic              half_o
);
  logic [DATA_W:0] wide;
  logic [4:0]      low;

  always_comb begin
    if (sub_i)
      wide = {1'b0, a_i} - {1'b0, b_i} - {{DATA_W{1'b0}}, cin_i};
    else
      wide = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin_i};
    low    = {1'b0, a_i[3:0]} + {1'b0, b_i[3:0]} + {4'd0, cin_i};
    res_o  = wide[DATA_W-1:0];
    cry_o  = wide[DATA_W];
    half_o = low[4];
    if (sub_i)
      ovf_o = (a_i[DATA_W-1] != b_i[DATA_W-1]) && (res_o[DATA_W-1] != a_i[DATA_W-1]);
    else
      ovf_o = (a_i[DATA_W-1] == b_i[DATA_W-1]) && (res_o[DATA_W-1] != a_i[DATA_W-1]);
  end
endmodule

// File: rtl/acc_bcd_adjust.sv
module acc_bcd_adjust
  import acc_flag_pkg::*;
(
  input  logic [DATA_W-1:0] a_i,
  input  logic              half_i,
  input  logic              cry_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cry_o
);
  logic lo_big, hi_big, lo_fix, hi_fix;

  always_comb begin
    lo_big = a_i[3:0] > 4'd9;
    hi_big = a_i[7:4] > 4'd9;
    lo_fix = half_i | lo_big;
    hi_fix = cry_i | hi_big | ((a_i[7:4] == 4'd9) & lo_big);
    res_o  = a_i + {1'b0, hi_fix, hi_fix, 1'b0, 1'b0, lo_fix, lo_fix, 1'b0};
    cry_o  = hi_fix;
  end
endmodule

// File: rtl/acc_ccr.sv
module acc_ccr
  import acc_flag_pkg::*;
#(
  parameter int N_IRQ = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we_i,
  input  logic [7:0]       wdata_i,
  input  logic [7:0]       upd_mask_i,
  input  logic [7:0]       upd_val_i,
  input  logic             stop_req_i,
  input  logic             nmi_req_i,
  input  logic [N_IRQ-1:0] irq_req_i,
  output logic [7:0]       ccr_o,
  output logic             stop_en_o,
  output logic             nmi_o,
  output logic             irq_o
);
  logic [7:0] ccr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ccr_q[B_STOP] <= 1'b1;
      ccr_q[B_NMIM] <= 1'b1;
      ccr_q[B_IRQM] <= 1'b1;
    end else if (we_i) begin
      ccr_q <= {wdata_i[7], ccr_q[B_NMIM] & wdata_i[6], wdata_i[5:0]};
    end else begin
      ccr_q <= (ccr_q & ~upd_mask_i) | (upd_val_i & upd_mask_i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stop_en_o <= 1'b0;
      nmi_o     <= 1'b0;
      irq_o     <= 1'b0;
    end else begin
      stop_en_o <= stop_req_i & ~ccr_q[B_STOP];
      nmi_o     <= nmi_req_i & ~ccr_q[B_NMIM];
      irq_o     <= (|irq_req_i) & ~ccr_q[B_IRQM];
    end
  end

  assign ccr_o = ccr_q;

  a_r1_ctrl_set: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ccr_q[B_STOP] && ccr_q[B_NMIM] && ccr_q[B_IRQM]));
  a_r7_nmi_sticky: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ccr_q[B_NMIM])) |-> !ccr_q[B_NMIM]);
  a_r9_irq_gate: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> !$past(ccr_q[B_IRQM]));
  a_r9_nmi_gate: assert property (@(posedge clk) disable iff (rst)
    nmi_o |-> !$past(ccr_q[B_NMIM]));
  a_r9_stop_gate: assert property (@(posedge clk) disable iff (rst)
    stop_en_o |-> !$past(ccr_q[B_STOP]));
endmodule

// File: rtl/acc_flag_unit.sv
module acc_flag_unit
  import acc_flag_pkg::*;
#(
  parameter int N_IRQ = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       op_i,
  input  logic [7:0]       opnd_i,
  input  logic             ccr_we_i,
  input  logic [7:0]       ccr_wdata_i,
  input  logic             stop_req_i,
  input  logic             nmi_req_i,
  input  logic [N_IRQ-1:0] irq_req_i,
  output logic [7:0]       acc_o,
  output logic [7:0]       ccr_o,
  output logic             stop_en_o,
  output logic             nmi_o,
  output logic             irq_o
);
  acc_op_e         op;
  logic [DATA_W-1:0] acc_q, acc_d;
  logic [DATA_W-1:0] ar_res, bcd_res;
  logic            ar_cry, ar_ovf, ar_half, bcd_cry;
  logic            use_cin, is_sub;
  logic [7:0]      upd_mask, upd_val;

  assign op      = acc_op_e'(op_i);
  assign is_sub  = (op == OP_SUB) || (op == OP_SBC);
  assign use_cin = ((op == OP_ADC) || (op == OP_SBC)) & ccr_o[B_CRY];

  acc_arith u_arith (
    .a_i(acc_q), .b_i(opnd_i), .cin_i(use_cin), .sub_i(is_sub),
    .res_o(ar_res), .cry_o(ar_cry), .ovf_o(ar_ovf), .half_o(ar_half)
  );

  acc_bcd_adjust u_bcd (
    .a_i(acc_q), .half_i(ccr_o[B_HALF]), .cry_i(ccr_o[B_CRY]),
    .res_o(bcd_res), .cry_o(bcd_cry)
  );

  always_comb begin
    acc_d    = acc_q;
    upd_mask = 8'h00;
    upd_val  = 8'h00;
    unique case (op)
      OP_LOAD: acc_d = opnd_i;
      OP_ADD, OP_ADC: begin
        acc_d    = ar_res;
        upd_mask = 8'h2F;
        upd_val[B_HALF] = ar_half;
      end
      OP_SUB, OP_SBC: begin
        acc_d    = ar_res;
        upd_mask = 8'h0F;
      end
      OP_DAA: begin
        acc_d    = bcd_res;
        upd_mask = 8'h0D;
      end
      default: ;
    endcase
    upd_val[B_NEG]  = acc_d[DATA_W-1];
    upd_val[B_ZERO] = (acc_d == '0);
    upd_val[B_OVF]  = ar_ovf;
    upd_val[B_CRY]  = (op == OP_DAA) ? bcd_cry : ar_cry;
  end

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= acc_d;
  end

  assign acc_o = acc_q;

  acc_ccr #(.N_IRQ(N_IRQ)) u_ccr (
    .clk(clk), .rst(rst), .we_i(ccr_we_i), .wdata_i(ccr_wdata_i),
    .upd_mask_i(upd_mask), .upd_val_i(upd_val),
    .stop_req_i(stop_req_i), .nmi_req_i(nmi_req_i), .irq_req_i(irq_req_i),
    .ccr_o(ccr_o), .stop_en_o(stop_en_o), .nmi_o(nmi_o), .irq_o(irq_o)
  );

  a_r4_half_kept: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ccr_we_i) && ($past(op_i) == 3'd4 || $past(op_i) == 3'd5))
      |-> (ccr_o[B_HALF] == $past(ccr_o[B_HALF])));
  a_r8_write_wins: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ccr_we_i))
      |-> ({ccr_o[7], ccr_o[5:0]} == {$past(ccr_wdata_i[7]), $past(ccr_wdata_i[5:0])}));
  a_r5_zero_flag: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ccr_we_i) && $past(op_i) >= 3'd2 && $past(op_i) <= 3'd6)
      |-> (ccr_o[B_ZERO] == (acc_o == 8'h00)));
  a_r2_load_keeps: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ccr_we_i) && $past(op_i) == 3'd1)
      |-> (ccr_o == $past(ccr_o)));
endmodule

// File: tb/acc_flag_unit_tb_top.sv
module acc_flag_unit_tb_top;
  localparam int N_IRQ = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [2:0]       op_i = 3'd0;
  logic [7:0]       opnd_i = 8'h00;
  logic             ccr_we_i = 1'b0;
  logic [7:0]       ccr_wdata_i = 8'h00;
  logic             stop_req_i = 1'b0;
  logic             nmi_req_i = 1'b0;
  logic [N_IRQ-1:0] irq_req_i = '0;
  logic [7:0]       acc_o, ccr_o;
  logic             stop_en_o, nmi_o, irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  acc_flag_unit #(.N_IRQ(N_IRQ)) dut_i (
    .clk(clk), .rst(rst), .op_i(op_i), .opnd_i(opnd_i),
    .ccr_we_i(ccr_we_i), .ccr_wdata_i(ccr_wdata_i),
    .stop_req_i(stop_req_i), .nmi_req_i(nmi_req_i), .irq_req_i(irq_req_i),
    .acc_o(acc_o), .ccr_o(ccr_o), .stop_en_o(stop_en_o), .nmi_o(nmi_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic do_op(input logic [2:0] code, input logic [7:0] b);
    @(negedge clk);
    op_i = code; opnd_i = b;
    @(negedge clk);
    op_i = 3'd0;
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk);
    ccr_we_i = 1'b1; ccr_wdata_i = d;
    @(negedge clk);
    ccr_we_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_reset_state();
    check("R1", "acc", acc_o, 8'h00);
    check("R1", "ctrl bits", ccr_o & 8'hD0, 8'hD0);
    check("R1", "gates", {5'd0, stop_en_o, nmi_o, irq_o}, 8'h00);
    do_write(8'hD0);
    check("R7", "ccr after write", ccr_o, 8'hD0);
  endtask

  task automatic t_bcd();
    do_op(3'd1, 8'h45);
    check("R2", "load acc", acc_o, 8'h45);
    check("R2", "load ccr", ccr_o, 8'hD0);
    do_op(3'd2, 8'h38);
    check("R3", "45+38", acc_o, 8'h7D);
    check("R3", "ccr", ccr_o, 8'hD0);
    do_op(3'd6, 8'h00);
    check("R6", "daa lo", acc_o, 8'h83);
    check("R5", "ccr N", ccr_o, 8'hD8);
    do_op(3'd1, 8'h48); do_op(3'd2, 8'h29);
    check("R3", "H set", ccr_o, 8'hF0);
    do_op(3'd6, 8'h00);
    check("R6", "daa from H", acc_o, 8'h77);
    check("R6", "ccr", ccr_o, 8'hF0);
    do_op(3'd1, 8'h99); do_op(3'd2, 8'h01);
    check("R3", "99+01", {acc_o}, 8'h9A);
    check("R5", "ccr", ccr_o, 8'hD8);
    do_op(3'd6, 8'h00);
    check("R6", "daa 9A", acc_o, 8'h00);
    check("R6", "ccr C Z", ccr_o, 8'hD5);
    do_op(3'd1, 8'h50); do_op(3'd2, 8'h50);
    check("R3", "50+50 ccr", ccr_o, 8'hDA);
    do_op(3'd6, 8'h00);
    check("R6", "daa hi", acc_o, 8'h00);
    check("R6", "ccr V kept", ccr_o, 8'hD7);
  endtask

  task automatic t_binary();
    do_op(3'd1, 8'h7F); do_op(3'd2, 8'h01);
    check("R3", "7F+01", acc_o, 8'h80);
    check("R3", "ccr ovf", ccr_o, 8'hFA);
    do_op(3'd1, 8'hFF); do_op(3'd2, 8'h01);
    check("R3", "FF+01", acc_o, 8'h00);
    check("R3", "ccr carry", ccr_o, 8'hF5);
    do_op(3'd1, 8'h10);
    check("R2", "load keeps C", ccr_o, 8'hF5);
    do_op(3'd7, 8'h55);
    check("R2", "nop7 acc", acc_o, 8'h10);
    do_op(3'd3, 8'h20);
    check("R3", "adc", acc_o, 8'h31);
    check("R3", "adc ccr", ccr_o, 8'hD0);
    do_op(3'd1, 8'h08); do_op(3'd2, 8'h08);
    check("R3", "H from add", ccr_o, 8'hF0);
    do_op(3'd4, 8'h20);
    check("R4", "10-20", acc_o, 8'hF0);
    check("R4", "borrow, H kept", ccr_o, 8'hF9);
    do_op(3'd1, 8'h50); do_op(3'd5, 8'h10);
    check("R4", "sbc", acc_o, 8'h3F);
    check("R4", "sbc ccr", ccr_o, 8'hF0);
    do_op(3'd1, 8'h80); do_op(3'd4, 8'h01);
    check("R4", "80-01", acc_o, 8'h7F);
    check("R4", "sub ovf", ccr_o, 8'hF2);
  endtask

  task automatic t_priority();
    do_op(3'd1, 8'h01);
    @(negedge clk);
    op_i = 3'd2; opnd_i = 8'h01; ccr_we_i = 1'b1; ccr_wdata_i = 8'hC0;
    @(negedge clk);
    op_i = 3'd0; ccr_we_i = 1'b0;
    check("R8", "acc still adds", acc_o, 8'h02);
    check("R8", "ccr from write", ccr_o, 8'hC0);
  endtask

  task automatic t_gates();
    do_write(8'hD0);
    stop_req_i = 1'b1; nmi_req_i = 1'b1; irq_req_i = 4'b0100;
    @(negedge clk); @(negedge clk);
    check("R9", "masked", {5'd0, stop_en_o, nmi_o, irq_o}, 8'h00);
    @(negedge clk);
    ccr_we_i = 1'b1; ccr_wdata_i = 8'h00;
    @(negedge clk);
    ccr_we_i = 1'b0;
    check("R9", "old mask used", {5'd0, stop_en_o, nmi_o, irq_o}, 8'h00);
    @(negedge clk);
    check("R9", "unmasked", {5'd0, stop_en_o, nmi_o, irq_o}, 8'h07);
    do_write(8'hFF);
    check("R7", "X sticky", ccr_o, 8'hBF);
    @(negedge clk);
    check("R9", "irq masked nmi open", {5'd0, stop_en_o, nmi_o, irq_o}, 8'h02);
    stop_req_i = 1'b0; nmi_req_i = 1'b0; irq_req_i = '0;
  endtask

  task automatic t_reset_keep();
    do_write(8'h2B);
    do_reset();
    check("R1", "flags kept, ctrl set", ccr_o, 8'hFB);
    check("R1", "acc cleared", acc_o, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_bcd();
    t_binary();
    t_priority();
    t_gates();
    t_reset_keep();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule